// File: doc/BRIEF.md
# Interrupt Request and Acknowledge Controller with Next-PC Steering

This block handles interrupts for a simple processor that completes one instruction per cycle. A device raises an asynchronous request line. The block passes that line through a chain of flip-flops into the processor clock domain. If the processor has not masked interrupts, the block accepts the request. It then acknowledges the device, masks further interrupts, and sends a one-cycle alert to the next-address logic.

The next-address logic is part of the block. Normally it picks the following PC from one of four sources: the incremented PC, a jump target, a register target, or a fixed system-call entry. In the alert cycle it replaces that choice with a fixed handler entry. It also stores the PC it would otherwise have picked, so the handler has a return address. The processor reopens interrupts with a clear control and closes them with a set control. The set control has priority when both are asserted.

Top module: `intr_gate`

## Requirements
- R1: During and after reset, before any request is accepted, the mask output is 1, acknowledge is 0, alert is 0 and the saved PC is 0.
- R2: A request is accepted only after it passes through SYNC_STAGES (default 2) flip-flops. With a request that rises before a clock edge and the mask clear, alert, acknowledge and mask all go high on the third rising edge, and not earlier.
- R3: Each accepted request gives an alert exactly one cycle wide, and the mask is 1 in that cycle.
- R4: Acknowledge stays high while the synchronized request is high. It goes low on the third rising edge after the device drops the request.
- R5: While the mask is 1, a request is ignored: no acknowledge and no alert.
- R6: A one-cycle pulse on mask_clr_i clears the mask at the next edge, and a pulse on mask_set_i sets it. When both are asserted in the same cycle, the mask ends up 1.
- R7: Without an alert, next_pc_o follows npc_sel_i. Code 0 gives pc_i+1, wrapping modulo 2^PC_W. Code 1 gives jump_tgt_i. Code 2 gives reg_tgt_i. Code 3 gives SYSCALL_ADDR (default 30'h2000_0040).
- R8: While the alert is high, next_pc_o equals HANDLER_ADDR (default 30'h2000_0060) whatever npc_sel_i is.
- R9: At the edge that ends the alert cycle, saved_pc_o loads the PC that R7 would have chosen in that cycle. At every other edge it keeps its value.
- R10: While acknowledge is still high, a request that stays asserted is not accepted a second time, even after the mask has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 1 | Asynchronous interrupt request from the device |
| irq_ack_o | output | 1 | Acknowledge to the device |
| irq_alert_o | output | 1 | One-cycle alert to the next-address logic |
| irq_mask_o | output | 1 | Current interrupt mask (1 means masked) |
| mask_set_i | input | 1 | Processor control that sets the mask |
| mask_clr_i | input | 1 | Processor control that clears the mask |
| npc_sel_i | input | 2 | Next-PC source code |
| pc_i | input | PC_W | Current word-address PC |
| jump_tgt_i | input | PC_W | Jump target |
| reg_tgt_i | input | PC_W | Register-indirect target |
| next_pc_o | output | PC_W | Selected next PC |
| saved_pc_o | output | PC_W | Return PC captured when an interrupt is taken |

## Verification
The assertions rely on three assumptions about the inputs. The mask controls are synchronous levels. A device keeps its request high until it sees the acknowledge. The PC and select inputs stay stable for a whole cycle. The bench changes every input on the falling clock edge and holds each request until the acknowledge has appeared. It pulses the mask controls for exactly one cycle, so the alert-cycle checks on next_pc_o and saved_pc_o compare against values that did not move during that cycle.

// File: rtl/intr_pkg.sv
package intr_pkg;
   typedef enum logic [1:0] {
      NPC_INCR = 2'd0,
      NPC_JUMP = 2'd1,
      NPC_REG  = 2'd2,
      NPC_SYSC = 2'd3
   } npc_sel_e;
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("intr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/intr_flags.sv
module intr_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic req_sync_i,
   input  logic mask_set_i,
   input  logic mask_clr_i,
   output logic ack_o,
   output logic alert_o,
   output logic mask_o
);
   logic ack_q, alert_q, mask_q;
   logic take;

   // Accept only a fresh request: unmasked and no acknowledge outstanding.
   assign take = req_sync_i & ~mask_q & ~ack_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         alert_q <= 1'b0;
         mask_q  <= 1'b1;
      end else begin
         alert_q <= take;
         if (take)             ack_q <= 1'b1;
         else if (!req_sync_i) ack_q <= 1'b0;
         // Set sources dominate the clear control.
         if (take || mask_set_i) mask_q <= 1'b1;
         else if (mask_clr_i)    mask_q <= 1'b0;
      end
   end

   assign ack_o   = ack_q;
   assign alert_o = alert_q;
   assign mask_o  = mask_q;
endmodule

// File: rtl/intr_npc.sv
module intr_npc
   import intr_pkg::*;
#(
   parameter int              PC_W         = 30,
   parameter logic [PC_W-1:0] SYSCALL_ADDR = '0,
   parameter logic [PC_W-1:0] HANDLER_ADDR = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alert_i,
   input  logic [1:0]      sel_i,
   input  logic [PC_W-1:0] pc_i,
   input  logic [PC_W-1:0] jump_tgt_i,
   input  logic [PC_W-1:0] reg_tgt_i,
   output logic [PC_W-1:0] next_pc_o,
   output logic [PC_W-1:0] saved_pc_o
);
   localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

   npc_sel_e        sel;
   logic [PC_W-1:0] normal_pc;
   logic [PC_W-1:0] saved_q;

   assign sel = npc_sel_e'(sel_i);

   always_comb begin
      unique case (sel)
         NPC_INCR: normal_pc = pc_i + PC_STEP;
         NPC_JUMP: normal_pc = jump_tgt_i;
         NPC_REG:  normal_pc = reg_tgt_i;
         NPC_SYSC: normal_pc = SYSCALL_ADDR;
         default:  normal_pc = pc_i + PC_STEP;
      endcase
   end

   assign next_pc_o = alert_i ? HANDLER_ADDR : normal_pc;

   always_ff @(posedge clk) begin
      if (!rst_n)       saved_q <= '0;
      else if (alert_i) saved_q <= normal_pc;
   end

   assign saved_pc_o = saved_q;
endmodule

// File: rtl/intr_gate.sv
module intr_gate #(
   parameter int              PC_W         = 30,
   parameter int              SYNC_STAGES  = 2,
   parameter logic [PC_W-1:0] SYSCALL_ADDR = PC_W'(32'h2000_0040),
   parameter logic [PC_W-1:0] HANDLER_ADDR = PC_W'(32'h2000_0060)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq_req_i,
   output logic            irq_ack_o,
   output logic            irq_alert_o,
   output logic            irq_mask_o,
   input  logic            mask_set_i,
   input  logic            mask_clr_i,
   input  logic [1:0]      npc_sel_i,
   input  logic [PC_W-1:0] pc_i,
   input  logic [PC_W-1:0] jump_tgt_i,
   input  logic [PC_W-1:0] reg_tgt_i,
   output logic [PC_W-1:0] next_pc_o,
   output logic [PC_W-1:0] saved_pc_o
);
   if (PC_W < 2) begin : g_bad_pcw
      $error("intr_gate: PC_W must be at least 2");
   end

   logic req_sync;
   logic alert;

   intr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (irq_req_i),
      .q_o   (req_sync)
   );

   intr_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_sync_i (req_sync),
      .mask_set_i (mask_set_i),
      .mask_clr_i (mask_clr_i),
      .ack_o      (irq_ack_o),
      .alert_o    (alert),
      .mask_o     (irq_mask_o)
   );

   intr_npc #(
      .PC_W         (PC_W),
      .SYSCALL_ADDR (SYSCALL_ADDR),
      .HANDLER_ADDR (HANDLER_ADDR)
   ) u_npc (
      .clk        (clk),
      .rst_n      (rst_n),
      .alert_i    (alert),
      .sel_i      (npc_sel_i),
      .pc_i       (pc_i),
      .jump_tgt_i (jump_tgt_i),
      .reg_tgt_i  (reg_tgt_i),
      .next_pc_o  (next_pc_o),
      .saved_pc_o (saved_pc_o)
   );

   assign irq_alert_o = alert;
endmodule

// File: rtl/intr_gate_chk.sv
module intr_gate_chk #(
   parameter int              PC_W         = 30,
   parameter logic [PC_W-1:0] HANDLER_ADDR = '0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ack,
   input logic            alert,
   input logic            mask,
   input logic            mask_set,
   input logic            mask_clr,
   input logic [PC_W-1:0] next_pc,
   input logic [PC_W-1:0] saved_pc
);
   // R3: the alert never lasts two cycles
   a_r3_alert_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      alert |=> !alert);
   // R3: the mask is already up while the alert is high
   a_r3_mask_with_alert: assert property (@(posedge clk) disable iff (!rst_n)
      alert |-> mask);
   // R8: the handler entry wins during the alert
   a_r8_handler_pc: assert property (@(posedge clk) disable iff (!rst_n)
      alert |-> next_pc == HANDLER_ADDR);
   // R9: the saved PC moves only at the end of an alert cycle
   a_r9_saved_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !alert |=> $stable(saved_pc));
   // R6: the set control always leaves the mask set
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      mask_set |=> mask);
   // R6: a lone clear control opens a set mask
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mask && mask_clr && !mask_set) |=> !mask);
   // R5: a mask that stays set lets no alert through
   a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask && !mask_clr) |=> !alert);
   // R4: the acknowledge rises only together with the alert
   a_r4_ack_with_alert: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> alert);
endmodule

bind intr_gate intr_gate_chk #(
   .PC_W         (PC_W),
   .HANDLER_ADDR (HANDLER_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ack      (irq_ack_o),
   .alert    (irq_alert_o),
   .mask     (irq_mask_o),
   .mask_set (mask_set_i),
   .mask_clr (mask_clr_i),
   .next_pc  (next_pc_o),
   .saved_pc (saved_pc_o)
);

// File: tb/tb_intr_gate.sv
module tb_intr_gate;
   localparam int PC_W = 30;
   localparam logic [PC_W-1:0] SYSC = 30'h2000_0040;
   localparam logic [PC_W-1:0] HAND = 30'h2000_0060;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, mset = 1'b0, mclr = 1'b0;
   logic [1:0] sel = 2'd0;
   logic [PC_W-1:0] pc = '0, jt = '0, rt = '0;
   logic ack, alert, mask;
   logic [PC_W-1:0] npc, spc;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   intr_gate #(.PC_W(PC_W), .SYNC_STAGES(2), .SYSCALL_ADDR(SYSC), .HANDLER_ADDR(HAND)) dut (
      .clk(clk), .rst_n(rst_n), .irq_req_i(req), .irq_ack_o(ack), .irq_alert_o(alert),
      .irq_mask_o(mask), .mask_set_i(mset), .mask_clr_i(mclr), .npc_sel_i(sel),
      .pc_i(pc), .jump_tgt_i(jt), .reg_tgt_i(rt), .next_pc_o(npc), .saved_pc_o(spc)
   );

   // {sel, pc, jump target, register target, expected next PC}
   localparam logic [121:0] NPC_VEC [6] = '{
      {2'd0, 30'h0000_0100, 30'h0000_0001, 30'h0000_0002, 30'h0000_0101},
      {2'd0, 30'h3FFF_FFFF, 30'h0000_0001, 30'h0000_0002, 30'h0000_0000},
      {2'd1, 30'h0000_0010, 30'h0ABC_DEF0, 30'h0000_0005, 30'h0ABC_DEF0},
      {2'd2, 30'h0000_0010, 30'h0000_0007, 30'h1234_5678, 30'h1234_5678},
      {2'd3, 30'h0000_0010, 30'h0000_0007, 30'h0000_0008, 30'h2000_0040},
      {2'd2, 30'h0000_0000, 30'h0000_0000, 30'h3FFF_FFFC, 30'h3FFF_FFFC}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   initial begin
      repeat (3) step();
      check("R1 mask", 32'(mask), 32'd1);
      check("R1 ack", 32'(ack), 32'd0);
      check("R1 alert", 32'(alert), 32'd0);
      check("R1 saved", 32'(spc), 32'd0);
      rst_n = 1'b1;
      step();
      check("R1 mask after reset", 32'(mask), 32'd1);

      // R7: next-PC selection table
      for (int i = 0; i < 6; i++) begin
         sel = NPC_VEC[i][121:120];
         pc  = NPC_VEC[i][119:90];
         jt  = NPC_VEC[i][89:60];
         rt  = NPC_VEC[i][59:30];
         #1;
         check("R7 next pc", 32'(npc), 32'(NPC_VEC[i][29:0]));
         step();
      end
      check("R9 saved held", 32'(spc), 32'd0);

      // R5: masked request ignored
      req = 1'b1;
      for (int i = 0; i < 6; i++) begin
         step();
         check("R5 no alert", 32'(alert), 32'd0);
      end
      check("R5 no ack", 32'(ack), 32'd0);
      req = 1'b0;
      repeat (4) step();

      // R6: simultaneous set and clear keep the mask set
      mset = 1'b1; mclr = 1'b1;
      step();
      mset = 1'b0; mclr = 1'b0;
      check("R6 both", 32'(mask), 32'd1);
      mclr = 1'b1;
      step();
      mclr = 1'b0;
      check("R6 clear", 32'(mask), 32'd0);

      // R2/R3/R8/R9: accepted request while jump selected
      sel = 2'd1; pc = 30'h0000_0200; jt = 30'h0155_0AA0; rt = 30'h0000_0333;
      req = 1'b1;
      step();
      check("R2 alert edge1", 32'(alert), 32'd0);
      step();
      check("R2 alert edge2", 32'(alert), 32'd0);
      check("R2 ack edge2", 32'(ack), 32'd0);
      step();
      check("R2 alert edge3", 32'(alert), 32'd1);
      check("R2 ack edge3", 32'(ack), 32'd1);
      check("R3 mask in alert", 32'(mask), 32'd1);
      check("R8 handler pc", 32'(npc), 32'(HAND));
      step();
      check("R3 alert one cycle", 32'(alert), 32'd0);
      check("R9 saved jump", 32'(spc), 32'(jt));
      check("R4 ack held", 32'(ack), 32'd1);
      check("R7 after alert", 32'(npc), 32'(jt));

      // R10: mask cleared while acknowledge outstanding
      mclr = 1'b1;
      step();
      mclr = 1'b0;
      check("R10 mask open", 32'(mask), 32'd0);
      for (int i = 0; i < 4; i++) begin
         step();
         check("R10 no second alert", 32'(alert), 32'd0);
      end
      check("R10 saved unchanged", 32'(spc), 32'(jt));

      // R4: acknowledge release timing
      req = 1'b0;
      step();
      check("R4 ack edge1", 32'(ack), 32'd1);
      step();
      check("R4 ack edge2", 32'(ack), 32'd1);
      step();
      check("R4 ack edge3", 32'(ack), 32'd0);

      // second interrupt with register target selected
      sel = 2'd2; rt = 30'h2AAA_5555;
      req = 1'b1;
      repeat (3) step();
      check("R2 second alert", 32'(alert), 32'd1);
      check("R8 handler over reg", 32'(npc), 32'(HAND));
      step();
      check("R9 saved reg", 32'(spc), 32'(rt));
      req = 1'b0;
      repeat (4) step();

      // R6: set control alone
      mclr = 1'b1;
      step();
      mclr = 1'b0;
      mset = 1'b1;
      step();
      mset = 1'b0;
      check("R6 set", 32'(mask), 32'd1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule